// File: doc/BRIEF.md
# Clock-Slave Synchronous Serial Receiver

This block receives serial words whose bit timing is set by a clock from outside the chip. The serial clock and data pins are brought into the system clock domain through a multi-flop synchronizer. Rising edges of the serial clock are found inside the system domain. On each rising edge one data bit is captured, least significant bit first. A word is 8 bits long, or 9 bits when the wide-word mode is selected.

When the last bit of a word arrives, the assembled word moves into a holding register. At the same time a completion flag is raised. That flag drives an interrupt request when the receive interrupt is enabled. While the system is in a low-power state, the same request is also presented as a wake request.

A status byte shows the configuration bits, the error flags and the ninth data bit. A word that finishes while the previous one is still unread sets an overrun error and is dropped. Transfers then stay blocked until software clears the continuous-receive enable, which is the only way to clear errors. The single-receive enable is accepted as an input and shown in status, but it plays no part in slave reception.

Top module: `sync_slave_rx`

## Requirements
- R1: Words are received only while port_en=1, sync_mode=1 and clk_master=0. With any one of these conditions not met, a complete serial word leaves rx_ready low and rx_data unchanged.
- R2: Reception runs only while cont_en=1. A word clocked in with cont_en=0 is not received. The level of single_en has no effect on reception or on the received values.
- R3: In 8-bit mode (wide_mode=0), bits are sampled on rising edges of sclk_in, least significant bit first. After the 8th rising edge, rx_data holds the word and rx_ready is 1.
- R4: In 9-bit mode (wide_mode=1), a word is 9 bits long. Bits 7..0 appear on rx_data and bit 8 appears on status[0]. In 8-bit mode, status[0] reads 0 after every received word.
- R5: status bit 7 is port_en, bit 6 is wide_mode, bit 5 is single_en, bit 4 is cont_en, bit 3 is addr_en, bit 2 is the framing error (always 0 in this mode), bit 1 is the overrun error, and bit 0 is the ninth data bit.
- R6: A one-cycle pulse on rd_pulse clears rx_ready on the next clock edge and leaves rx_data and status[0] unchanged.
- R7: irq is 1 exactly when rx_ready=1 and irq_en=1.
- R8: Reception continues while low_power=1. wake_req is 1 exactly when irq=1 and low_power=1.
- R9: A word that completes while rx_ready=1 and no read pulse is given sets the overrun bit (status[1]) and is discarded. While the overrun bit is set, every further word is discarded and rx_ready is not set again.
- R10: Driving cont_en low clears the overrun bit on the next clock edge and discards any partly received word. The next word after re-enabling starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock source select; 0 means clock comes from outside |
| cont_en | input | 1 | Continuous-receive enable; low clears errors |
| single_en | input | 1 | Single-receive enable; no effect in slave reception |
| wide_mode | input | 1 | 1 selects 9-bit words |
| addr_en | input | 1 | Address-detect enable, reported in status only |
| irq_en | input | 1 | Receive interrupt enable |
| low_power | input | 1 | System is in a sleep or idle state |
| sclk_in | input | 1 | External serial clock (asynchronous) |
| sdata_in | input | 1 | Serial data (asynchronous) |
| rd_pulse | input | 1 | One-cycle read of the receive data register |
| rx_data | output | DATA_W | Received data, low bits |
| status | output | 8 | Status byte |
| rx_ready | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt request |
| wake_req | output | 1 | Wake request during low power |

## Verification
A rising edge on sclk_in passes through two synchronizer flops and one edge-detect flop. For that reason rx_ready, rx_data, status[0] and the overrun bit change on the third system clock edge after the serial edge. Each serial clock phase in the bench lasts six system clocks, and results are sampled at the falling system clock edge at the end of the final high phase, after that latency has passed. A read pulse or a change of cont_en acts on the next system edge, and the bench samples at the falling edge that follows it. irq and wake_req are combinational from rx_ready, so they are checked in the same sample.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

   // Status byte, most significant field first; order is decoded by software.
   typedef struct packed {
      logic port_en;
      logic wide_mode;
      logic single_en;
      logic cont_en;
      logic addr_en;
      logic frame_err;
      logic ovr_err;
      logic bit9;
   } rx_status_t;

   localparam int STATUS_W = $bits(rx_status_t);

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("srx_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] pipe_q [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[g] <= '0;
               else        pipe_q[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[g] <= '0;
               else        pipe_q[g] <= pipe_q[g-1];
            end
         end
      end
   endgenerate

   assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wide_mode,
   input  logic              sclk_s,
   input  logic              sdata_s,
   output logic              word_done,
   output logic [DATA_W:0]   word
);

   localparam int MAX_W = DATA_W + 1;
   localparam int CNT_W = $clog2(MAX_W);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("srx_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx;
   logic [MAX_W-1:0] sh_q;

   assign rise     = sclk_s & ~prev_q;
   assign last_idx = wide_mode ? CNT_W'(MAX_W - 1) : CNT_W'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (rise) begin
         sh_q[cnt_q] <= sdata_s;
         if (cnt_q == last_idx) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      word        = sh_q;
      word[cnt_q] = sdata_s;
   end

   assign word_done = active & rise & (cnt_q == last_idx);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_W - 1));                                   // R4
   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> cnt_q == '0);                                      // R10
   AST_DONE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> $past(active));                                  // R1

endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cont_en,
   input  logic              wide_mode,
   input  logic              word_done,
   input  logic [DATA_W:0]   word,
   input  logic              rd_pulse,
   output logic [DATA_W-1:0] data_q,
   output logic              bit9_q,
   output logic              ready_q,
   output logic              ovr_q
);

   logic unread;
   logic accept;
   logic overrun_hit;

   assign unread      = ready_q & ~rd_pulse;
   assign accept      = word_done & ~ovr_q & ~unread;
   assign overrun_hit = word_done & ~ovr_q & unread;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         bit9_q <= 1'b0;
      end else if (accept) begin
         data_q <= word[DATA_W-1:0];
         bit9_q <= wide_mode & word[DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ready_q <= 1'b0;
      else if (accept)    ready_q <= 1'b1;
      else if (rd_pulse)  ready_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ovr_q <= 1'b0;
      else if (!cont_en)    ovr_q <= 1'b0;
      else if (overrun_hit) ovr_q <= 1'b1;
   end

   AST_OVR_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> $stable(data_q));                                    // R9
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_en |=> !ovr_q);                                          // R10
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pulse && !word_done) |=> !ready_q);                        // R6
   AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !ovr_q) |=> ready_q);                            // R3

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
   import sync_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              sync_mode,
   input  logic              clk_master,
   input  logic              cont_en,
   input  logic              single_en,
   input  logic              wide_mode,
   input  logic              addr_en,
   input  logic              irq_en,
   input  logic              low_power,
   input  logic              sclk_in,
   input  logic              sdata_in,
   input  logic              rd_pulse,
   output logic [DATA_W-1:0] rx_data,
   output logic [7:0]        status,
   output logic              rx_ready,
   output logic              irq,
   output logic              wake_req
);

   generate
      if (STATUS_W != 8) begin : g_bad_status
         $error("sync_slave_rx: status layout must be 8 bits");
      end
   endgenerate

   logic [1:0]      pins_s;
   logic            active;
   logic            word_done;
   logic [DATA_W:0] word;
   logic            bit9_q;
   logic            ovr_q;
   rx_status_t      stat;

   // Slave reception: port on, synchronous, clock from outside, continuous enable.
   assign active = port_en & sync_mode & ~clk_master & cont_en;

   srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({sclk_in, sdata_in}),
      .dout  (pins_s)
   );

   srx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .wide_mode (wide_mode),
      .sclk_s    (pins_s[1]),
      .sdata_s   (pins_s[0]),
      .word_done (word_done),
      .word      (word)
   );

   srx_holding #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cont_en   (cont_en),
      .wide_mode (wide_mode),
      .word_done (word_done),
      .word      (word),
      .rd_pulse  (rd_pulse),
      .data_q    (rx_data),
      .bit9_q    (bit9_q),
      .ready_q   (rx_ready),
      .ovr_q     (ovr_q)
   );

   always_comb begin
      stat.port_en   = port_en;
      stat.wide_mode = wide_mode;
      stat.single_en = single_en;
      stat.cont_en   = cont_en;
      stat.addr_en   = addr_en;
      stat.frame_err = 1'b0;
      stat.ovr_err   = ovr_q;
      stat.bit9      = bit9_q;
   end

   assign status   = stat;
   assign irq      = rx_ready & irq_en;
   assign wake_req = irq & low_power;

   AST_WAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (rx_ready && low_power));                         // R8
   AST_FRAME_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[2] == 1'b0);                                            // R5

endmodule

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_en = 1'b0, sync_mode = 1'b0, clk_master = 1'b0;
   logic       cont_en = 1'b0, single_en = 1'b0, wide_mode = 1'b0;
   logic       addr_en = 1'b0, irq_en = 1'b0, low_power = 1'b0;
   logic       sclk_in = 1'b0, sdata_in = 1'b0, rd_pulse = 1'b0;
   logic [7:0] rx_data;
   logic [7:0] status;
   logic       rx_ready, irq, wake_req;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sync_slave_rx uut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
      .clk_master(clk_master), .cont_en(cont_en), .single_en(single_en),
      .wide_mode(wide_mode), .addr_en(addr_en), .irq_en(irq_en),
      .low_power(low_power), .sclk_in(sclk_in), .sdata_in(sdata_in),
      .rd_pulse(rd_pulse), .rx_data(rx_data), .status(status),
      .rx_ready(rx_ready), .irq(irq), .wake_req(wake_req)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [8:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         sclk_in  = 1'b0;
         sdata_in = w[i];
         repeat (6) @(negedge clk);
         sclk_in = 1'b1;
         repeat (6) @(negedge clk);
      end
      sclk_in = 1'b0;
   endtask

   task automatic read_word();
      rd_pulse = 1'b1;
      @(negedge clk);
      rd_pulse = 1'b0;
   endtask

   function automatic logic [7:0] exp_status(input logic ovr, input logic b9);
      return {port_en, wide_mode, single_en, cont_en, addr_en, 1'b0, ovr, b9};
   endfunction

   task automatic slave_on();
      port_en = 1'b1; sync_mode = 1'b1; clk_master = 1'b0; cont_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 reset status", 16'(status), 16'h00);
      check("R3 reset data", 16'(rx_data), 16'h00);
      check("R7 reset ready/irq", {14'd0, rx_ready, irq}, 16'd0);

      // Status layout with configuration bits set, no reception
      port_en = 1'b1; wide_mode = 1'b1; single_en = 1'b1; addr_en = 1'b1;
      @(negedge clk);
      check("R5 status layout", 16'(status), 16'(8'b1110_1000));
      wide_mode = 1'b0; single_en = 1'b0; addr_en = 1'b0;

      // R1: gating conditions block reception
      slave_on();
      clk_master = 1'b1;
      send_bits(9'h0A5, 8);
      check("R1 clk_master blocks", {15'd0, rx_ready}, 16'd0);
      clk_master = 1'b0; sync_mode = 1'b0;
      send_bits(9'h0A5, 8);
      check("R1 sync_mode blocks", {15'd0, rx_ready}, 16'd0);
      sync_mode = 1'b1; port_en = 1'b0;
      send_bits(9'h0A5, 8);
      check("R1 port_en blocks", {15'd0, rx_ready}, 16'd0);
      check("R1 data unchanged", 16'(rx_data), 16'h00);

      // R2: cont_en low blocks reception
      slave_on();
      cont_en = 1'b0;
      single_en = 1'b1;
      @(negedge clk);
      send_bits(9'h03C, 8);
      check("R2 cont_en low blocks", {15'd0, rx_ready}, 16'd0);
      single_en = 1'b0;
      cont_en = 1'b1;
      @(negedge clk);

      // R3/R4/R6/R7/R8: exhaustive 8-bit sweep
      for (int v = 0; v < 256; v++) begin
         irq_en    = v[1];
         low_power = v[2];
         single_en = v[3];
         send_bits(9'(v), 8);
         check("R3 8-bit data", 16'(rx_data), 16'(v));
         check("R3 ready set", {15'd0, rx_ready}, 16'd1);
         check("R4 bit9 zero in 8-bit", 16'(status), 16'(exp_status(1'b0, 1'b0)));
         check("R7 irq", {15'd0, irq}, {15'd0, v[1]});
         check("R8 wake", {15'd0, wake_req}, {15'd0, v[1] & v[2]});
         read_word();
         check("R6 read clears ready", {15'd0, rx_ready}, 16'd0);
         check("R6 data kept", 16'(rx_data), 16'(v));
      end

      // R4/R2: exhaustive 9-bit sweep, single_en toggling
      wide_mode = 1'b1;
      irq_en = 1'b1; low_power = 1'b0;
      @(negedge clk);
      for (int v = 0; v < 512; v++) begin
         single_en = v[0] ^ v[4];
         send_bits(9'(v), 9);
         check("R4 9-bit data", 16'(rx_data), 16'(v & 255));
         check("R4 9th bit in status", 16'(status), 16'(exp_status(1'b0, v[8])));
         read_word();
         check("R6 bit9 kept", {15'd0, status[0]}, {15'd0, v[8]});
      end
      wide_mode = 1'b0; single_en = 1'b0;
      @(negedge clk);

      // R9: overrun
      send_bits(9'h011, 8);
      send_bits(9'h022, 8);
      check("R9 overrun set", 16'(status), 16'(exp_status(1'b1, 1'b0)));
      check("R9 first word kept", 16'(rx_data), 16'h11);
      send_bits(9'h033, 8);
      check("R9 still first word", 16'(rx_data), 16'h11);
      read_word();
      send_bits(9'h044, 8);
      check("R9 blocked after read", {15'd0, rx_ready}, 16'd0);
      check("R9 data frozen", 16'(rx_data), 16'h11);

      // R10: clearing cont_en clears the error
      cont_en = 1'b0;
      @(negedge clk);
      check("R10 overrun cleared", {15'd0, status[1]}, 16'd0);
      cont_en = 1'b1;
      @(negedge clk);
      send_bits(9'h055, 8);
      check("R10 receive resumes", 16'(rx_data), 16'h55);
      read_word();

      // R10: partial word discarded
      send_bits(9'h1FF, 3);
      cont_en = 1'b0;
      @(negedge clk);
      cont_en = 1'b1;
      @(negedge clk);
      send_bits(9'h081, 8);
      check("R10 partial discarded", 16'(rx_data), 16'h81);
      check("R10 ready after restart", {15'd0, rx_ready}, 16'd1);
      read_word();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule